// File: doc/BRIEF.md
# Selectable-Delay Guard-Gate Transient Filter

This block keeps short single-event glitches on a combinational net from reaching the flip-flop that captures that net. It is modelled in an oversampled clock domain: one clock tick of `clk` stands for the delay of one inverter stage. The incoming signal `din` runs into a shift line of `DEPTH` stages, twelve by default. A three-bit code on `tap_sel` picks one stage of that line as a delayed reference. The live input and the delayed reference drive a C-element. The C-element's output moves to the shared value when the two inputs agree, and holds its last value while they disagree.

A pulse narrower than or equal to the chosen delay is never present on both C-element inputs in the same tick, so it never reaches `dout`. A wider pulse appears at `dout` with its full width, later by the chosen number of ticks. The bypass code gives zero added delay and no filtering, for paths with no timing margin. The data path carries one sample per tick with no stall, so there is no valid/ready handshake: the filter has to accept every sample, and a stall would change the delay it models.

Top module: `gg_transient_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `clk` edge) clears every delay stage and the held C-element state to 0. While reset is held, `dout` is 0 at any nonzero tap. After release with `din` held at 1 and tap code 4, `dout` stays 0 for 12 ticks and becomes 1 in the 13th.
- R2: Tap code map: 0 gives bypass (0 stages), 1 gives 3 stages, 2 gives 5 stages, 3 gives 8 stages, and 4 gives 12 stages. Codes 5, 6 and 7 act exactly like code 4.
- R3: With code 0, `dout` equals `din` in the same tick, for every pulse width.
- R4: With a selected delay of d > 0 stages, a 0-to-1 pulse of width W <= d ticks on a settled-low input leaves `dout` at 0 throughout.
- R5: With a selected delay of d stages and W > d, a 0-to-1 pulse that starts in tick t0 drives `dout` to 1 in ticks t0+d through t0+W+d-1 and to 0 otherwise. The width is kept and the pulse is shifted by d.
- R6: Low-going pulses on a settled-high input follow the same rules as R4 and R5, with the polarity inverted.
- R7: `dout` only ever changes to the value `din` has in that same tick. While `din` and the delayed reference disagree, `dout` holds its previous value.
- R8: A change of `tap_sel` takes effect in the tick in which it is applied. If `dout` equals `din` and `din` stays unchanged, switching taps cannot move `dout`, even when a suppressed glitch still sits in the delay line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, one tick per stage delay |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Unfiltered combinational signal |
| tap_sel | input | 3 | Delay selection code (see R2) |
| dout | output | 1 | Filtered signal toward the capture flop |

## Verification
A corrupted delay stage shows up at `dout` exactly d ticks after it enters the line, as a pulse that starts or ends early, or as a glitch that leaks through. The per-tick comparison over the whole pulse window therefore catches it within one pulse length. A held C-element state that is stuck or wrongly reset shows up as a missing or stretched edge in the first pulse whose inputs disagree. A wrong tap decode shifts every edge of a wide pulse by a fixed amount, so it is visible on that pulse's first edge.

// File: rtl/gg_pkg.sv
package gg_pkg;

  localparam int GG_SEL_W = 3;

  typedef enum logic [GG_SEL_W-1:0] {
    GG_SEL_BYPASS = 3'd0,
    GG_SEL_SHORT  = 3'd1,
    GG_SEL_MID    = 3'd2,
    GG_SEL_LONG   = 3'd3,
    GG_SEL_FULL   = 3'd4
  } gg_sel_e;

  // Number of delay stages chosen by a tap code; codes above FULL saturate.
  function automatic int gg_stages(input logic [GG_SEL_W-1:0] code,
                                   input int s_short, input int s_mid,
                                   input int s_long, input int s_full);
    case (code)
      GG_SEL_BYPASS: return 0;
      GG_SEL_SHORT:  return s_short;
      GG_SEL_MID:    return s_mid;
      GG_SEL_LONG:   return s_long;
      default:       return s_full;
    endcase
  endfunction

endpackage

// File: rtl/gg_delay_line.sv
module gg_delay_line #(
  parameter int DEPTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);

  // taps[k] holds din as it was k+1 ticks ago
  always_ff @(posedge clk) begin
    if (rst) taps[0] <= 1'b0;
    else     taps[0] <= din;
  end

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) taps[k] <= 1'b0;
        else     taps[k] <= taps[k-1];
      end
    end
  endgenerate

  // R1
  line_clear_chk: assert property (@(posedge clk) rst |=> (taps == '0));

endmodule

// File: rtl/gg_tap_mux.sv
module gg_tap_mux
  import gg_pkg::*;
#(
  parameter int DEPTH   = 12,
  parameter int S_SHORT = 3,
  parameter int S_MID   = 5,
  parameter int S_LONG  = 8
) (
  input  logic                din,
  input  logic [DEPTH-1:0]    taps,
  input  logic [GG_SEL_W-1:0] sel,
  output logic                ref_out
);

  int n_stages;

  always_comb begin
    n_stages = gg_stages(sel, S_SHORT, S_MID, S_LONG, DEPTH);
    ref_out  = din;  // zero stages: the reference is the live input
    for (int k = 0; k < DEPTH; k++) begin
      if (n_stages == k + 1) ref_out = taps[k];
    end
  end

endmodule

// File: rtl/gg_celement.sv
module gg_celement (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  output logic y
);

  logic held_q;

  always_comb y = (a == b) ? a : held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= y;
  end

  // R7
  agree_move_chk: assert property (@(posedge clk) disable iff (rst)
    (y != $past(y)) |-> (a == b));

  // R1
  state_clear_chk: assert property (@(posedge clk) rst |=> (held_q == 1'b0));

endmodule

// File: rtl/gg_transient_filter.sv
module gg_transient_filter
  import gg_pkg::*;
#(
  parameter int DEPTH   = 12,
  parameter int S_SHORT = 3,
  parameter int S_MID   = 5,
  parameter int S_LONG  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                din,
  input  logic [GG_SEL_W-1:0] tap_sel,
  output logic                dout
);

  logic [DEPTH-1:0] line_taps;
  logic             ref_bit;

  gg_delay_line #(.DEPTH(DEPTH)) u_line (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .taps (line_taps)
  );

  gg_tap_mux #(
    .DEPTH   (DEPTH),
    .S_SHORT (S_SHORT),
    .S_MID   (S_MID),
    .S_LONG  (S_LONG)
  ) u_mux (
    .din     (din),
    .taps    (line_taps),
    .sel     (tap_sel),
    .ref_out (ref_bit)
  );

  gg_celement u_guard (
    .clk (clk),
    .rst (rst),
    .a   (din),
    .b   (ref_bit),
    .y   (dout)
  );

  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (tap_sel == GG_SEL_BYPASS) |-> (dout == din));

  // R7
  move_to_din_chk: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> (dout == din));

  // R8
  steady_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dout == din) ##1 $stable(din) |-> $stable(dout));

endmodule

// File: tb/test_gg_transient_filter.sv
`timescale 1ns/1ps
module test_gg_transient_filter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [2:0] tap_sel = 3'd4;
  logic       dout;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  gg_transient_filter i_gg_transient_filter (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .tap_sel (tap_sel),
    .dout    (dout)
  );

  function automatic int exp_delay(input logic [2:0] code);
    case (code)
      3'd0: return 0;
      3'd1: return 3;
      3'd2: return 5;
      3'd3: return 8;
      default: return 12;
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input logic v);
    @(posedge clk); #1 din = v;
  endtask

  task automatic settle(input logic v, input int n);
    for (int i = 0; i < n; i++) tick(v);
  endtask

  // R1: reset state, then cleared history seen at the port
  task automatic t_reset;
    rst = 1'b1; din = 1'b1; tap_sel = 3'd4;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(dout, 1'b0, "R1 reset state");
    @(posedge clk); #1 rst = 1'b0;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      chk(dout, (c >= 12), "R1 cleared line after release");
      @(posedge clk); #1;
    end
  endtask

  // R2 R3 R4 R5 R6 R7: one pulse of width w at code, polarity pos
  task automatic t_pulse(input logic [2:0] code, input int w, input logic pos);
    int d;
    logic base, exp;
    string tag;
    d = exp_delay(code);
    base = ~pos;
    tap_sel = code;
    settle(base, 14);
    @(negedge clk);
    chk(dout, base, "R7 settled level");
    for (int c = 0; c < w + d + 3; c++) begin
      @(posedge clk); #1 din = (c < w) ? ~base : base;
      @(negedge clk);
      exp = ((w > d) && (c >= d) && (c < w + d)) ? ~base : base;
      if (code > 3'd4)                          tag = "R2 saturated code";
      else if (d == 0)                          tag = "R3 bypass";
      else if (!pos)                            tag = "R6 low pulse";
      else if (w <= d)                          tag = "R4 suppressed";
      else if (c >= w && c < w + d)             tag = "R7 hold";
      else                                      tag = "R5 shifted pulse";
      chk(dout, exp, tag);
    end
  endtask

  // R8: tap switching with steady input, including a glitch in the line
  task automatic t_tap_switch;
    tap_sel = 3'd4;
    settle(1'b1, 14);
    for (int code = 0; code < 8; code++) begin
      @(posedge clk); #1 tap_sel = 3'(code);
      @(negedge clk);
      chk(dout, 1'b1, "R8 switch on steady input");
    end
    @(posedge clk); #1 tap_sel = 3'd4; din = 1'b0;
    @(negedge clk); chk(dout, 1'b1, "R8 glitch held");
    @(posedge clk); #1 din = 1'b0;
    @(negedge clk); chk(dout, 1'b1, "R8 glitch held");
    @(posedge clk); #1 din = 1'b1;
    @(negedge clk); chk(dout, 1'b1, "R8 glitch ends");
    for (int i = 0; i < 9; i++) begin
      @(posedge clk); #1 tap_sel = 3'(1 + (i % 3));
      @(negedge clk);
      chk(dout, 1'b1, "R8 switch over stored glitch");
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    t_reset();
    for (int code = 0; code < 8; code++) begin
      for (int w = 1; w <= 14; w++) begin
        t_pulse(3'(code), w, 1'b1);
      end
    end
    for (int code = 1; code < 5; code++) begin
      for (int w = 1; w <= 14; w++) begin
        t_pulse(3'(code), w, 1'b0);
      end
    end
    t_tap_switch();
    t_reset();
    finish_run();
  end

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

endmodule